// File: doc/BRIEF.md
# Conditional Call/Return Sequencer

This block steps through a program that is kept as a ring of 512 slots, each 16 bytes wide. For every instruction that the decoder hands over, it updates a byte-address program counter. It also counts down the instructions left in the run and resolves the two control-flow kinds, call and return. Both are conditional. A call that fires saves two words on a private 64-bit stack and jumps a short distance forward. A return that fires takes those two words back, jumps to the saved address and merges the saved word into its result. Decode, operand fetch and arithmetic happen upstream. The block only receives the instruction kind, operands A and B, a 32-bit immediate and an 8-bit immediate.

Each accepted instruction produces registered results one clock later: the program counter of the next instruction, and, for control-flow kinds, a 64-bit result with a valid strobe. When the countdown reaches zero, a done flag rises and all further issues are dropped. The stack depth is a parameter. A call that finds the stack full is downgraded to not taken and sets a sticky overflow flag.

Top module: `flow_ctl_unit`

## Requirements
- R1: After reset `next_pc` is 0, the stack is empty, and `result_vld`, `run_done` and `stack_ovf` are all 0.
- R2: A call or return fires only when `opnd_b`, taken as an unsigned 64-bit value, is less than or equal to `imm_wide` zero-extended to 64 bits.
- R3: A call or return that does not fire gives `result_c` = `opnd_a`, `result_vld` = 1 and `next_pc` = previous `next_pc` + 16, all one clock after the issue.
- R4: A firing call (`issue_kind` = 2'b01) first stores A and then stores the return address, which is previous `next_pc` + 16. It sets `next_pc` to that return address + 16 × (`imm_narrow[6:0]` + 1), gives `result_c` = A, and ignores `imm_narrow[7]`.
- R5: A firing return (`issue_kind` = 2'b10) first takes back the return address and then the stored word. It sets `result_c` = A XOR stored word and `next_pc` = return address.
- R6: A return issued while the stack holds no saved pair behaves as not fired (R3).
- R7: A call that meets its condition while the stack already holds STACK_DEPTH/2 pairs behaves as not fired and leaves the stack unchanged. It sets `stack_ovf`, which then stays 1 until reset.
- R8: Kinds 2'b00 and 2'b11 advance `next_pc` by 16 and leave `result_vld` at 0.
- R9: Every accepted issue decrements a countdown that starts at IC_INIT. Once IC_INIT issues have been accepted, `run_done` is 1 and later issues change nothing.
- R10: `next_pc` is a byte address that is always a multiple of 16 and wraps modulo PROG_BYTES (8192).
- R11: A cycle with `issue_vld` = 0 leaves `next_pc` unchanged and `result_vld` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_vld | input | 1 | An instruction is presented this cycle |
| issue_kind | input | 2 | 01 call, 10 return, 00/11 other |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B, used in the condition |
| imm_wide | input | 32 | 32-bit immediate, the condition bound |
| imm_narrow | input | 8 | 8-bit immediate; bits 6:0 give the call distance |
| next_pc | output | 13 | Byte address of the next instruction |
| result_c | output | 64 | Result of the last control-flow instruction |
| result_vld | output | 1 | `result_c` was produced by the previous issue |
| run_done | output | 1 | Countdown has reached zero |
| stack_ovf | output | 1 | Sticky: a call was refused because the stack was full |

## Verification
The assertions assume that `issue_vld`, `issue_kind`, `opnd_b` and `imm_wide` hold known values whenever an issue is presented. They also assume that outputs are judged only one clock after an issue, never in the same cycle. The bench drives every input at a single point well clear of the rising edge and keeps all four kind codes and both sides of the B-versus-immediate bound in its stimulus. This includes equality and operands whose upper 32 bits are set. The stack depth is overridden to a small value so that the full-stack refusal is actually reached.

// File: rtl/flow_ctl_pkg.sv
package flow_ctl_pkg;

    typedef enum logic [1:0] {
        KIND_OTHER_LO = 2'b00,
        KIND_CALL     = 2'b01,
        KIND_RET      = 2'b10,
        KIND_OTHER_HI = 2'b11
    } insn_kind_e;

    localparam int unsigned SLOT_BYTES = 16;
    localparam int unsigned HOP_MASK   = 8'h7F;

endpackage

// File: rtl/flow_ctl_stack.sv
module flow_ctl_stack #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned WORD_W = 64,
    parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] wr_val,
    input  logic [WORD_W-1:0] wr_ret,
    output logic [WORD_W-1:0] rd_val,
    output logic [WORD_W-1:0] rd_ret,
    output logic              full,
    output logic              empty
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [LVL_W-1:0]  level_d, level_q;
    logic [IDX_W-1:0]  idx_lo;

    assign idx_lo = level_q[IDX_W-1:0];
    assign full   = (level_q > LVL_W'(DEPTH - 2));
    assign empty  = (level_q < LVL_W'(2));
    assign rd_ret = mem[idx_lo - IDX_W'(1)];
    assign rd_val = mem[idx_lo - IDX_W'(2)];

    always_comb begin
        level_d = level_q;
        if (push && !full) begin
            level_d = level_q + LVL_W'(2);
        end else if (pop && !empty) begin
            level_d = level_q - LVL_W'(2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= level_d;
        end
    end

    // Data word goes in first (lower slot), return address above it.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[idx_lo]              <= wr_val;
            mem[idx_lo + IDX_W'(1)]  <= wr_ret;
        end
    end

endmodule

// File: rtl/flow_ctl_decide.sv
module flow_ctl_decide
    import flow_ctl_pkg::*;
#(
    parameter int unsigned PC_W   = 13,
    parameter int unsigned WORD_W = 64
) (
    input  logic              act,
    input  logic [1:0]        kind,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [31:0]       imm_wide,
    input  logic [7:0]        imm_narrow,
    input  logic [PC_W-1:0]   pc_q,
    input  logic              stk_full,
    input  logic              stk_empty,
    output logic              call_go,
    output logic              call_blk,
    output logic              ret_go,
    output logic [PC_W-1:0]   pc_seq,
    output logic [PC_W-1:0]   pc_far
);
    logic        cond_ok;
    logic        is_call;
    logic        is_ret;
    logic [7:0]  hop_slots;
    logic [11:0] hop_bytes;

    assign is_call   = (kind == KIND_CALL);
    assign is_ret    = (kind == KIND_RET);
    assign cond_ok   = (opnd_b <= {{(WORD_W-32){1'b0}}, imm_wide});

    assign hop_slots = (imm_narrow & 8'(HOP_MASK)) + 8'd1;
    assign hop_bytes = {hop_slots, 4'b0000};

    assign pc_seq    = pc_q + PC_W'(SLOT_BYTES);
    assign pc_far    = pc_seq + PC_W'(hop_bytes);

    assign call_go   = act && is_call && cond_ok && !stk_full;
    assign call_blk  = act && is_call && cond_ok &&  stk_full;
    assign ret_go    = act && is_ret  && cond_ok && !stk_empty;

endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
    import flow_ctl_pkg::*;
#(
    parameter int unsigned PROG_BYTES  = 8192,
    parameter int unsigned STACK_DEPTH = 64,
    parameter int unsigned IC_INIT     = 1048576,
    parameter int unsigned WORD_W      = 64,
    localparam int unsigned PC_W       = $clog2(PROG_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [1:0]        issue_kind,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [31:0]       imm_wide,
    input  logic [7:0]        imm_narrow,
    output logic [PC_W-1:0]   next_pc,
    output logic [WORD_W-1:0] result_c,
    output logic              result_vld,
    output logic              run_done,
    output logic              stack_ovf
);
    localparam int unsigned IC_W = $clog2(IC_INIT + 1);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [IC_W-1:0]   ic;
        logic [WORD_W-1:0] c;
        logic              cvld;
        logic              ovf;
    } cu_state_t;

    cu_state_t st_d, st_q;

    insn_kind_e        kind_e;
    logic              act;
    logic              call_go, call_blk, ret_go;
    logic [PC_W-1:0]   pc_seq, pc_far, pc_back;
    logic [WORD_W-1:0] rd_val, rd_ret, wr_ret;
    logic              stk_full, stk_empty;

    assign kind_e  = insn_kind_e'(issue_kind);
    assign act     = issue_vld && (st_q.ic != '0);
    assign wr_ret  = WORD_W'(pc_seq);
    assign pc_back = PC_W'(rd_ret % WORD_W'(PROG_BYTES));

    flow_ctl_decide #(
        .PC_W   (PC_W),
        .WORD_W (WORD_W)
    ) u_decide (
        .act        (act),
        .kind       (issue_kind),
        .opnd_b     (opnd_b),
        .imm_wide   (imm_wide),
        .imm_narrow (imm_narrow),
        .pc_q       (st_q.pc),
        .stk_full   (stk_full),
        .stk_empty  (stk_empty),
        .call_go    (call_go),
        .call_blk   (call_blk),
        .ret_go     (ret_go),
        .pc_seq     (pc_seq),
        .pc_far     (pc_far)
    );

    flow_ctl_stack #(
        .DEPTH  (STACK_DEPTH),
        .WORD_W (WORD_W)
    ) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (call_go),
        .pop    (ret_go),
        .wr_val (opnd_a),
        .wr_ret (wr_ret),
        .rd_val (rd_val),
        .rd_ret (rd_ret),
        .full   (stk_full),
        .empty  (stk_empty)
    );

    always_comb begin
        st_d      = st_q;
        st_d.cvld = 1'b0;
        if (act) begin
            st_d.ic = st_q.ic - IC_W'(1);
            unique case (kind_e)
                KIND_CALL: begin
                    st_d.cvld = 1'b1;
                    st_d.c    = opnd_a;
                    st_d.pc   = call_go ? pc_far : pc_seq;
                    st_d.ovf  = st_q.ovf | call_blk;
                end
                KIND_RET: begin
                    st_d.cvld = 1'b1;
                    st_d.c    = ret_go ? (opnd_a ^ rd_val) : opnd_a;
                    st_d.pc   = ret_go ? pc_back : pc_seq;
                end
                default: begin
                    st_d.pc   = pc_seq;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pc: '0, ic: IC_W'(IC_INIT), c: '0, cvld: 1'b0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc    = st_q.pc;
    assign result_c   = st_q.c;
    assign result_vld = st_q.cvld;
    assign run_done   = (st_q.ic == '0);
    assign stack_ovf  = st_q.ovf;

endmodule

// File: rtl/flow_ctl_unit_chk.sv
module flow_ctl_unit_chk #(
    parameter int unsigned PC_W = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_vld,
    input logic [1:0]      issue_kind,
    input logic [63:0]     opnd_a,
    input logic [63:0]     opnd_b,
    input logic [31:0]     imm_wide,
    input logic [PC_W-1:0] next_pc,
    input logic [63:0]     result_c,
    input logic            result_vld,
    input logic            run_done,
    input logic            stack_ovf
);
    logic live_cf;
    logic live_plain;
    assign live_cf    = issue_vld && !run_done && (issue_kind == 2'b01 || issue_kind == 2'b10);
    assign live_plain = issue_vld && !run_done && (issue_kind[0] == issue_kind[1]);

    a_r10_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        next_pc[3:0] == 4'h0);

    a_r9_done_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> (run_done && !result_vld && next_pc == $past(next_pc)));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf |=> stack_ovf);

    a_r3_not_taken_move: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cf && (opnd_b > {32'h0, imm_wide}))
        |=> (result_vld && result_c == $past(opnd_a)
             && next_pc == $past(next_pc) + PC_W'(16)));

    a_r8_plain_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        live_plain |=> (!result_vld && next_pc == $past(next_pc) + PC_W'(16)));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> (!result_vld && $stable(next_pc)));

endmodule

bind flow_ctl_unit flow_ctl_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_vld  (issue_vld),
    .issue_kind (issue_kind),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .imm_wide   (imm_wide),
    .next_pc    (next_pc),
    .result_c   (result_c),
    .result_vld (result_vld),
    .run_done   (run_done),
    .stack_ovf  (stack_ovf)
);

// File: tb/flow_ctl_unit_tb.sv
`timescale 1ns/1ps
module flow_ctl_unit_tb;
    localparam int DEPTH = 8;
    localparam int ICN   = 400;
    localparam int RING  = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [1:0]  issue_kind = 2'b00;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic [31:0] imm_wide = '0;
    logic [7:0]  imm_narrow = '0;
    logic [12:0] next_pc;
    logic [63:0] result_c;
    logic        result_vld, run_done, stack_ovf;

    always #2 clk = ~clk;

    flow_ctl_unit #(.STACK_DEPTH(DEPTH), .IC_INIT(ICN)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_kind(issue_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_wide(imm_wide), .imm_narrow(imm_narrow),
        .next_pc(next_pc), .result_c(result_c), .result_vld(result_vld),
        .run_done(run_done), .stack_ovf(stack_ovf)
    );

    int vectors = 0;
    int misses  = 0;

    // reference state
    int          m_pc = 0;
    int          m_ic = ICN;
    bit [63:0]   m_c = '0;
    bit          m_vld = 0;
    bit          m_ovf = 0;
    bit [63:0]   m_stk[$];

    task automatic compare(string tag);
        vectors++;
        if (next_pc !== 13'(m_pc) || result_vld !== m_vld || run_done !== (m_ic == 0)
            || stack_ovf !== m_ovf || (m_vld && result_c !== m_c)) begin
            misses++;
            $display("FAIL %s: got pc=%0d vld=%0b c=%h done=%0b ovf=%0b exp pc=%0d vld=%0b c=%h done=%0b ovf=%0b",
                     tag, next_pc, result_vld, result_c, run_done, stack_ovf,
                     m_pc, m_vld, m_c, (m_ic == 0), m_ovf);
        end
    endtask

    task automatic model(bit v, bit [1:0] k, bit [63:0] a, bit [63:0] b, bit [31:0] iw, bit [7:0] in8);
        int seq;
        bit cond;
        m_vld = 0;
        if (!v || m_ic == 0) return;
        seq  = (m_pc + 16) % RING;
        cond = (b <= {32'h0, iw});
        m_ic--;
        if (k == 2'b01) begin
            m_vld = 1; m_c = a; m_pc = seq;
            if (cond && m_stk.size() + 2 <= DEPTH) begin
                m_stk.push_back(a);
                m_stk.push_back(64'(seq));
                m_pc = (seq + 16 * (int'(in8 & 8'h7F) + 1)) % RING;
            end else if (cond) begin
                m_ovf = 1;
            end
        end else if (k == 2'b10) begin
            m_vld = 1; m_c = a; m_pc = seq;
            if (cond && m_stk.size() >= 2) begin
                bit [63:0] ra, sv;
                ra = m_stk.pop_back();
                sv = m_stk.pop_back();
                m_c  = a ^ sv;
                m_pc = int'(ra % 64'(RING));
            end
        end else begin
            m_pc = seq;
        end
    endtask

    task automatic step(string tag, bit v, bit [1:0] k, bit [63:0] a, bit [63:0] b,
                        bit [31:0] iw, bit [7:0] in8);
        issue_vld = v; issue_kind = k; opnd_a = a; opnd_b = b;
        imm_wide = iw; imm_narrow = in8;
        model(v, k, a, b, iw, in8);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R1 after release");

        // R8 plain kinds
        step("R8", 1, 2'b00, 64'h11, 64'h0, 32'h0, 8'h00);
        step("R8", 1, 2'b11, 64'h22, 64'h0, 32'h0, 8'h00);
        // R11 idle
        step("R11", 0, 2'b01, 64'h33, 64'h0, 32'h5, 8'h05);
        step("R11", 0, 2'b10, 64'h44, 64'h0, 32'h5, 8'h05);

        // R6 return on empty stack
        step("R6", 1, 2'b10, 64'hDEAD, 64'h0, 32'h0, 8'h00);

        // R2/R3 bound cases: equal fires, one above and upper bits block
        step("R3 b above", 1, 2'b01, 64'hA1, 64'd101, 32'd100, 8'h03);
        step("R3 b upper", 1, 2'b01, 64'hA2, 64'h1_0000_0000, 32'hFFFF_FFFF, 8'h03);
        step("R2 equal", 1, 2'b01, 64'hCAFE_0001, 64'd100, 32'd100, 8'h03);
        // R4 bit 7 of the narrow immediate ignored
        step("R4 bit7", 1, 2'b01, 64'hCAFE_0002, 64'd0, 32'd0, 8'h85);
        // R3 return blocked by bound
        step("R3 ret blocked", 1, 2'b10, 64'h55, 64'd9, 32'd8, 8'h00);
        // R5 returns unwind in order
        step("R5", 1, 2'b10, 64'hF0F0, 64'd8, 32'd8, 8'h00);
        step("R5", 1, 2'b10, 64'h0F0F, 64'd0, 32'd1, 8'h00);
        step("R6 drained", 1, 2'b10, 64'h77, 64'd0, 32'd1, 8'h00);

        // R7 fill stack, then refused call
        for (int i = 0; i < DEPTH / 2; i++)
            step("R7 fill", 1, 2'b01, 64'(i + 100), 64'd0, 32'd0, 8'(i));
        step("R7 refused", 1, 2'b01, 64'h999, 64'd0, 32'd0, 8'h10);
        step("R7 sticky", 1, 2'b00, 64'h0, 64'd0, 32'd0, 8'h00);
        for (int i = 0; i < DEPTH / 2; i++)
            step("R5 unwind", 1, 2'b10, 64'(i * 3), 64'd0, 32'd0, 8'h00);
        step("R6 empty", 1, 2'b10, 64'h1, 64'd0, 32'd0, 8'h00);

        // R10 long hops wrap the ring
        for (int i = 0; i < DEPTH / 2; i++)
            step("R10 wrap", 1, 2'b01, 64'(i), 64'd0, 32'd0, 8'h7F);
        for (int i = 0; i < DEPTH / 2; i++)
            step("R10 return", 1, 2'b10, 64'hFFFF, 64'd0, 32'd0, 8'h00);

        // mixed traffic until countdown expires
        while (m_ic > 0) begin
            bit [31:0] iw;
            bit [63:0] b;
            iw = $urandom() & 32'hFF;
            b  = ($urandom() % 2 == 0) ? 64'(iw) - 64'($urandom() % 2) : 64'(iw) + 64'd1;
            step("R2 mixed", ($urandom() % 5) != 0, 2'($urandom()), {$urandom(), $urandom()},
                 b, iw, 8'($urandom()));
        end
        for (int i = 0; i < 6; i++)
            step("R9 after done", 1, 2'(i), 64'(i), 64'd0, 32'd5, 8'h01);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule